// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of sources with fixed priorities and decides when to interrupt the CPU and which source to report. Source 0 has the highest priority. Each larger index has a lower priority.

A request line that is high at a clock edge is latched as pending. It stays pending until the CPU acknowledges that source. The CPU sees `cpu_irq` and answers with a one-cycle `ack`. In that clock the winning source leaves the pending set and joins the in-service set, and its index appears on `vec`. When a handler finishes, the CPU pulses `eos`. This retires the level currently in service, which is the highest-priority in-service source.

Two modes are chosen by the `nest_en` pin, which is held static between resets.
- **Sequential mode:** no new interrupt is raised while any service is active.
- **Nested mode:** only a pending source of strictly higher priority than the current level raises a new interrupt. Each retirement then returns to the level that was interrupted.

The control state machine has three states:
- `ST_IDLE`: nothing is in service.
- `ST_SINGLE`: exactly one level is in service.
- `ST_NESTED`: two or more levels are in service.

Its transitions are:
- GRANT: `ST_IDLE` to `ST_SINGLE`, on an accepted acknowledge.
- PREEMPT: `ST_SINGLE` to `ST_NESTED`, when a second level enters service.
- FINISH: `ST_SINGLE` to `ST_IDLE`, when the last level retires.
- RESUME: `ST_NESTED` to `ST_SINGLE`, when the in-service set drops back to one level.

Every other case holds the state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq`, `svc_busy`, `vec` and `svc_lvl` are all 0.
- R2: A source whose `req` bit is high at any clock edge stays pending, even after its request drops, until that source is acknowledged. The acknowledge clears it in that same clock.
- R3: The pending source with the lowest index wins. An accepted acknowledge puts its index on `vec` one clock later, and `vec` holds that value until the next accepted acknowledge.
- R4: With `irq_en` high, nothing in service and at least one source pending, `cpu_irq` is high in the cycle after the request is latched.
- R5: With `nest_en` low, `cpu_irq` stays low while a service is active and at most one level is ever in service. Requests that arrive during a service stay pending and raise `cpu_irq` once `eos` ends that service.
- R6: With `nest_en` high and a service active, `cpu_irq` is high only when the best pending index is strictly lower than `svc_lvl`. A request of equal or lower priority waits.
- R7: `eos` retires the in-service level with the lowest index. `svc_lvl` then shows the next-lowest in-service index, which is the interrupted level, or shows 0 with `svc_busy` low once nothing remains in service.
- R8: An `ack` while `cpu_irq` is low has no effect on `vec`, `svc_busy`, `svc_lvl` or the pending set.
- R9: With `irq_en` low, `cpu_irq` is low, but requests are still latched. They raise `cpu_irq` as soon as `irq_en` returns high.
- R10: An `eos` while nothing is in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nest_en | input | 1 | 1 selects nested mode, 0 selects sequential mode; held static between resets |
| irq_en | input | 1 | Global interrupt enable |
| req | input | NUM_SRC | Level request lines; bit i is source i, and bit 0 has the highest priority |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| eos | input | 1 | One-cycle end-of-service strobe |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec | output | IDX_W | Index of the most recently acknowledged source |
| svc_busy | output | 1 | High while any level is in service |
| svc_lvl | output | IDX_W | Lowest in-service index (current level), or 0 when idle |

## Verification
The bench uses four kinds of input pattern.

A single request pulse that is gone before the acknowledge separates level latching from direct pass-through.

A request that arrives during a sequential service, followed by retirement, separates the hold-off rule from plain masking.

In nested mode, requests of lower, equal and higher priority arrive against an active level, followed by a chain of retirements. Together these separate strict from non-strict comparison and show whether control returns to the interrupted level.

A burst of several simultaneous requests, served one by one, confirms the fixed priority order. Stray `ack` and `eos` strobes, and a dropped `irq_en`, show that those cases leave state untouched.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_NESTED = 2'd2
    } svc_state_e;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec_in,
    output logic         found,
    output logic [W-1:0] idx
);
    // Lowest set bit wins: scan downward so the last hit is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_in[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_pend_reg.sv
module pic_pend_reg #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         take,
    input  logic [W-1:0] take_idx,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;
    logic [N-1:0] clr;

    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr[g] = take && (take_idx == W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | req) & ~clr;
        end
    end

    assign pend = pend_q;

    // R3: only a source that is actually pending can be granted
    assert_take_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_q[take_idx]);

    // R2: a pending bit is lost only through a grant of that source
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && pend_q != '0) |=> ((($past(pend_q)) & ~pend_q) == '0));
endmodule

// File: rtl/pic_isr_stack.sv
module pic_isr_stack #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_idx,
    input  logic         pop,
    output logic [N-1:0] isv,
    output logic [N-1:0] isv_nxt,
    output logic         busy,
    output logic [W-1:0] cur_idx
);
    logic [N-1:0] isv_q;
    logic [N-1:0] low_bit;
    logic [N-1:0] pop_mask;
    logic [N-1:0] push_mask;

    for (genvar g = 0; g < N; g++) begin : g_push
        assign push_mask[g] = push && (push_idx == W'(g));
    end

    assign low_bit  = isv_q & (~isv_q + {{(N-1){1'b0}}, 1'b1});
    assign pop_mask = (pop && (isv_q != '0)) ? low_bit : '0;
    assign isv_nxt  = (isv_q & ~pop_mask) | push_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isv_q <= '0;
        end else begin
            isv_q <= isv_nxt;
        end
    end

    pic_prio_enc #(.N(N), .W(W)) u_cur_enc (
        .vec_in (isv_q),
        .found  (busy),
        .idx    (cur_idx)
    );

    assign isv = isv_q;

    // R6: a level already in service is never granted again
    assert_no_repush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !isv_q[push_idx]);

    // R10: retiring with nothing in service leaves the set empty
    assert_idle_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && isv_q == '0) |=> (isv_q == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nest_en,
    input  logic               irq_en,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ack,
    input  logic               eos,
    output logic               cpu_irq,
    output logic [IDX_W-1:0]   vec,
    output logic               svc_busy,
    output logic [IDX_W-1:0]   svc_lvl
);
    svc_state_e state_q, state_d;

    logic [NUM_SRC-1:0] pend;
    logic               pend_any;
    logic [IDX_W-1:0]   best_idx;
    logic [NUM_SRC-1:0] isv;
    logic [NUM_SRC-1:0] isv_nxt;
    logic               isv_any;
    logic [IDX_W-1:0]   cur_idx;
    logic               grant;
    logic               nxt_any;
    logic               nxt_multi;
    logic               irq_int;
    logic [IDX_W-1:0]   vec_q;

    pic_pend_reg #(.N(NUM_SRC), .W(IDX_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .take     (grant),
        .take_idx (best_idx),
        .pend     (pend)
    );

    pic_prio_enc #(.N(NUM_SRC), .W(IDX_W)) u_best_enc (
        .vec_in (pend),
        .found  (pend_any),
        .idx    (best_idx)
    );

    pic_isr_stack #(.N(NUM_SRC), .W(IDX_W)) u_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (grant),
        .push_idx (best_idx),
        .pop      (eos),
        .isv      (isv),
        .isv_nxt  (isv_nxt),
        .busy     (isv_any),
        .cur_idx  (cur_idx)
    );

    assign grant     = ack && irq_int;
    assign nxt_any   = (isv_nxt != '0);
    assign nxt_multi = ((isv_nxt & (isv_nxt - {{(NUM_SRC-1){1'b0}}, 1'b1})) != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: GRANT, PREEMPT, FINISH, RESUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant) state_d = ST_SINGLE;          // GRANT
            end
            ST_SINGLE: begin
                if (nxt_multi)     state_d = ST_NESTED;  // PREEMPT
                else if (!nxt_any) state_d = ST_IDLE;    // FINISH
            end
            ST_NESTED: begin
                if (!nxt_multi) state_d = ST_SINGLE;     // RESUME
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        irq_int  = 1'b0;
        svc_busy = 1'b0;
        svc_lvl  = '0;
        unique case (state_q)
            ST_IDLE: begin
                irq_int = irq_en && pend_any;
            end
            ST_SINGLE, ST_NESTED: begin
                svc_busy = 1'b1;
                svc_lvl  = cur_idx;
                irq_int  = irq_en && pend_any && nest_en && (best_idx < cur_idx);
            end
            default: begin
                irq_int = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (grant) begin
            vec_q <= best_idx;
        end
    end

    assign cpu_irq = irq_int;
    assign vec     = vec_q;

    // R5: no interrupt raised during a sequential-mode service
    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_en && isv_any) |-> !cpu_irq);

    // R5: sequential mode never stacks a second level
    assert_seq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nest_en |-> $onehot0(isv));

    // R6: pre-emption only by a strictly better source
    assert_preempt_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && isv_any) |-> (best_idx < cur_idx));

    // R7: state machine agrees with the in-service set
    assert_state_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) == (isv == '0));

    // R7: retiring from a nested stack resumes a lower-priority level
    assert_eos_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !grant && state_q == ST_NESTED) |=> (svc_lvl > $past(svc_lvl)));

    // R3: accepted acknowledge reports the winner
    assert_ack_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (vec == $past(best_idx)));

    // R8: ignored acknowledge keeps the vector
    assert_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cpu_irq) |=> $stable(vec));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int W     = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nest_en = 1'b0;
    logic         irq_en = 1'b1;
    logic [N-1:0] req = '0;
    logic         ack = 1'b0;
    logic         eos = 1'b0;
    logic         cpu_irq;
    logic [W-1:0] vec;
    logic         svc_busy;
    logic [W-1:0] svc_lvl;

    int    compared   = 0;
    int    mismatched = 0;
    bit    done       = 0;
    string cur_req    = "R1";

    // Behavioural reference state
    bit [N-1:0] m_pend;
    bit [N-1:0] m_isv;
    int         m_vec;

    always #(CLK_P / 2) clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nest_en  (nest_en),
        .irq_en   (irq_en),
        .req      (req),
        .ack      (ack),
        .eos      (eos),
        .cpu_irq  (cpu_irq),
        .vec      (vec),
        .svc_busy (svc_busy),
        .svc_lvl  (svc_lvl)
    );

    function automatic int lowest(bit [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    function automatic bit m_irq();
        int b, c;
        b = lowest(m_pend);
        c = lowest(m_isv);
        if (!irq_en || b == N) return 0;
        if (c == N) return 1;
        return nest_en && (b < c);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0;
            m_isv  = '0;
            m_vec  = 0;
        end else begin
            int  b, c;
            bit  g;
            b = lowest(m_pend);
            c = lowest(m_isv);
            g = ack && m_irq();
            for (int i = 0; i < N; i++) m_pend[i] = m_pend[i] | req[i];
            if (eos && c != N) m_isv[c] = 1'b0;
            if (g) begin
                m_pend[b] = 1'b0;
                m_isv[b]  = 1'b1;
                m_vec     = b;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int c;
            c = lowest(m_isv);
            chk({cur_req, " cpu_irq"}, int'(cpu_irq), int'(m_irq()));
            chk({cur_req, " svc_busy"}, int'(svc_busy), int'(c != N));
            chk({cur_req, " svc_lvl"}, int'(svc_lvl), (c == N) ? 0 : c);
            chk({cur_req, " vec"}, int'(vec), m_vec);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_req(bit [N-1:0] r);
        req = r;
        step();
        req = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic do_eos();
        eos = 1'b1;
        step();
        eos = 1'b0;
    endtask

    task automatic restart(bit nest);
        rst_n = 1'b0;
        step();
        nest_en = nest;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        restart(1'b0);
        cur_req = "R1";
        chk("R1 cpu_irq", int'(cpu_irq), 0);
        chk("R1 svc_busy", int'(svc_busy), 0);
        chk("R1 vec", int'(vec), 0);
        chk("R1 svc_lvl", int'(svc_lvl), 0);

        // Sequential mode
        cur_req = "R4";
        pulse_req(8'b0010_0000);
        chk("R4 irq after latch", int'(cpu_irq), 1);
        cur_req = "R2";
        step();
        step();
        chk("R2 still pending", int'(cpu_irq), 1);
        cur_req = "R3";
        do_ack();
        chk("R3 vec", int'(vec), 5);
        chk("R3 lvl", int'(svc_lvl), 5);
        cur_req = "R5";
        pulse_req(8'b0000_0010);
        step();
        chk("R5 held off", int'(cpu_irq), 0);
        do_eos();
        chk("R5 busy cleared", int'(svc_busy), 0);
        chk("R5 irq after eos", int'(cpu_irq), 1);
        do_ack();
        chk("R5 vec", int'(vec), 1);
        do_eos();

        cur_req = "R8";
        do_ack();
        chk("R8 busy", int'(svc_busy), 0);
        chk("R8 vec", int'(vec), 1);
        chk("R8 irq", int'(cpu_irq), 0);
        cur_req = "R10";
        do_eos();
        chk("R10 busy", int'(svc_busy), 0);
        chk("R10 irq", int'(cpu_irq), 0);

        cur_req = "R9";
        irq_en = 1'b0;
        pulse_req(8'b0000_1000);
        step();
        chk("R9 masked", int'(cpu_irq), 0);
        irq_en = 1'b1;
        #1;
        chk("R9 unmasked", int'(cpu_irq), 1);
        do_ack();
        chk("R9 vec", int'(vec), 3);
        do_eos();

        cur_req = "R3";
        pulse_req(8'b1010_0100);
        do_ack();
        chk("R3 burst first", int'(vec), 2);
        do_eos();
        do_ack();
        chk("R3 burst second", int'(vec), 5);
        do_eos();
        do_ack();
        chk("R3 burst third", int'(vec), 7);
        do_eos();

        // Nested mode
        restart(1'b1);
        cur_req = "R1";
        chk("R1 nested reset", int'(svc_busy), 0);
        cur_req = "R6";
        pulse_req(8'b0010_0000);
        do_ack();
        chk("R6 lvl5", int'(svc_lvl), 5);
        pulse_req(8'b0100_0000);
        chk("R6 lower waits", int'(cpu_irq), 0);
        pulse_req(8'b0010_0000);
        chk("R6 equal waits", int'(cpu_irq), 0);
        pulse_req(8'b0000_0100);
        chk("R6 higher pre-empts", int'(cpu_irq), 1);
        do_ack();
        chk("R6 vec2", int'(vec), 2);
        chk("R6 lvl2", int'(svc_lvl), 2);
        pulse_req(8'b0000_0001);
        chk("R6 top pre-empts", int'(cpu_irq), 1);
        do_ack();
        chk("R6 lvl0", int'(svc_lvl), 0);
        chk("R6 busy", int'(svc_busy), 1);
        cur_req = "R7";
        do_eos();
        chk("R7 back to 2", int'(svc_lvl), 2);
        do_eos();
        chk("R7 back to 5", int'(svc_lvl), 5);
        chk("R7 no irq at 5", int'(cpu_irq), 0);
        do_eos();
        chk("R7 idle", int'(svc_busy), 0);
        chk("R7 irq resumes", int'(cpu_irq), 1);
        do_ack();
        chk("R7 vec5", int'(vec), 5);
        do_eos();
        do_ack();
        chk("R7 vec6", int'(vec), 6);
        do_eos();
        chk("R7 final idle", int'(svc_busy), 0);
        step();

        done = 1;
        summary();
        $finish;
    end
endmodule